// File: doc/BRIEF.md
# Endian-Selectable Load/Store Byte Lane Unit

This unit sits between a 32-bit processor datapath and a byte-addressed data memory that is one word wide. On the load side it takes the word read from memory, the two low address bits and the access kind, picks the addressed byte lane, and returns a value ready for the register file: the whole word, a sign-extended byte or a zero-extended byte. On the store side it places the store data so that it lands in the right lane and produces one byte-enable bit per lane.

A static mode input chooses how byte offsets inside a word are numbered: offset 0 as the most significant byte, or offset 0 as the least significant byte. Whole-word transfers do not depend on the mode; only byte accesses do. A word access with non-zero low address bits is reported on a flag and writes nothing; it is never split into pieces.

All outputs are registered. Values presented on the inputs before a rising clock edge appear on the outputs after that edge. There are no states beyond this single output register stage.

Top module: `lsu_lane_unit`

## Requirements
- R1: While rst_n is low the outputs ld_value, wr_word, wr_be and misalign are all zero.
- R2: Outputs change only at a rising clock edge and reflect the inputs sampled at that edge; between edges they hold.
- R3: With kind 2'b00 (word) and addr_lo 2'b00, ld_value equals rd_word unchanged, whatever the value of big_endian.
- R4: With big_endian low, byte offset k (addr_lo) selects rd_word bits 8k+7 down to 8k, so offset 0 is bits 7:0 and offset 3 is bits 31:24.
- R5: With big_endian high, byte offset k selects rd_word bits 31-8k down to 24-8k, so offset 0 is bits 31:24 and offset 3 is bits 7:0.
- R6: With kind 2'b01 (signed byte), ld_value bits 31:8 all copy bit 7 of the selected byte.
- R7: With kind 2'b10 (unsigned byte), and also with the reserved code 2'b11, ld_value bits 31:8 are zero.
- R8: A word store (st_en high, kind 2'b00, addr_lo 2'b00) gives wr_word equal to st_data and wr_be equal to 4'b1111 in either mode.
- R9: A byte store (st_en high, kind not 2'b00) gives wr_word equal to st_data[7:0] repeated in all four lanes and exactly one wr_be bit high: bit j, where lane j is wr_word bits 8j+7:8j and is the lane chosen as in R4/R5.
- R10: A word access with addr_lo not 2'b00 sets misalign, forces wr_be to zero and ld_value to zero; byte accesses never set misalign.
- R11: With st_en low, wr_be is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| big_endian | input | 1 | 1: offset 0 is the most significant byte; 0: offset 0 is the least significant byte |
| kind | input | 2 | Access kind: 00 word, 01 signed byte, 10 unsigned byte, 11 reserved (acts as unsigned byte) |
| addr_lo | input | 2 | Byte offset within the word |
| st_en | input | 1 | High for a store access |
| rd_word | input | 32 | Word read from data memory |
| st_data | input | 32 | Register value to store |
| ld_value | output | 32 | Aligned and extended load result |
| wr_word | output | 32 | Write data with the byte placed in its lane |
| wr_be | output | 4 | Per-lane write enables, bit j for bits 8j+7:8j |
| misalign | output | 1 | Word access with non-zero low address bits |

## Verification
The only internal state is the output register, so a wrong lane decode or extension shows on ld_value, wr_word or wr_be one clock after the offending inputs and never later. A swapped endian decode surfaces as the mirror-image lane, which the vectors expose by reading a word whose four bytes all differ and two of which are negative. A wrong enable decode shows as zero or several wr_be bits for a byte store, or as a write on a misaligned word, both visible at the first edge after the access.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

    typedef enum logic [1:0] {
        ACC_WORD  = 2'b00,
        ACC_SBYTE = 2'b01,
        ACC_UBYTE = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

endpackage

// File: rtl/lsu_lane_map.sv
module lsu_lane_map #(
    parameter int NB = 4
) (
    input  logic [$clog2(NB)-1:0] off,
    input  logic                  big_endian,
    output logic [NB-1:0]         lane_sel
);
    localparam int OFF_W = $clog2(NB);

    // One decoder per physical lane; mode picks which offset owns it.
    for (genvar k = 0; k < NB; k++) begin : g_lane
        assign lane_sel[k] = big_endian ? (off == OFF_W'(NB - 1 - k))
                                        : (off == OFF_W'(k));
    end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_lane_pkg::*;
#(
    parameter int NB     = 4,
    parameter int BYTE_W = 8
) (
    input  logic [NB-1:0]        lane_sel,
    input  logic [NB*BYTE_W-1:0] rd_word,
    input  acc_kind_e            kind,
    output logic [NB*BYTE_W-1:0] byte_value
);
    localparam int DATA_W = NB * BYTE_W;

    logic [BYTE_W-1:0] picked;
    logic              fill;

    always_comb begin
        picked = '0;
        for (int k = 0; k < NB; k++) begin
            if (lane_sel[k]) begin
                picked = picked | rd_word[k*BYTE_W +: BYTE_W];
            end
        end
        fill       = (kind == ACC_SBYTE) ? picked[BYTE_W-1] : 1'b0;
        byte_value = {{(DATA_W - BYTE_W){fill}}, picked};
    end

endmodule

// File: rtl/lsu_store_place.sv
module lsu_store_place
    import lsu_lane_pkg::*;
#(
    parameter int NB     = 4,
    parameter int BYTE_W = 8
) (
    input  logic [NB-1:0]        lane_sel,
    input  logic [NB*BYTE_W-1:0] st_data,
    input  acc_kind_e            kind,
    input  logic                 st_en,
    input  logic                 word_bad,
    output logic [NB*BYTE_W-1:0] wr_word,
    output logic [NB-1:0]        wr_be
);
    always_comb begin
        if (kind == ACC_WORD) begin
            wr_word = st_data;
            wr_be   = (st_en && !word_bad) ? {NB{1'b1}} : '0;
        end else begin
            wr_word = {NB{st_data[BYTE_W-1:0]}};
            wr_be   = st_en ? lane_sel : '0;
        end
    end

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
    import lsu_lane_pkg::*;
#(
    parameter int NB     = 4,
    parameter int BYTE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       big_endian,
    input  logic [1:0]                 kind,
    input  logic [$clog2(NB)-1:0]      addr_lo,
    input  logic                       st_en,
    input  logic [NB*BYTE_W-1:0]       rd_word,
    input  logic [NB*BYTE_W-1:0]       st_data,
    output logic [NB*BYTE_W-1:0]       ld_value,
    output logic [NB*BYTE_W-1:0]       wr_word,
    output logic [NB-1:0]              wr_be,
    output logic                       misalign
);
    localparam int DATA_W = NB * BYTE_W;

    acc_kind_e          kind_e;
    logic [NB-1:0]      lane_sel;
    logic [DATA_W-1:0]  byte_value;
    logic [DATA_W-1:0]  ld_next;
    logic [DATA_W-1:0]  wr_word_next;
    logic [NB-1:0]      wr_be_next;
    logic               word_bad;

    assign kind_e   = acc_kind_e'(kind);
    assign word_bad = (kind_e == ACC_WORD) && (addr_lo != '0);

    lsu_lane_map #(.NB(NB)) u_map (
        .off        (addr_lo),
        .big_endian (big_endian),
        .lane_sel   (lane_sel)
    );

    lsu_load_extract #(.NB(NB), .BYTE_W(BYTE_W)) u_load (
        .lane_sel   (lane_sel),
        .rd_word    (rd_word),
        .kind       (kind_e),
        .byte_value (byte_value)
    );

    lsu_store_place #(.NB(NB), .BYTE_W(BYTE_W)) u_store (
        .lane_sel (lane_sel),
        .st_data  (st_data),
        .kind     (kind_e),
        .st_en    (st_en),
        .word_bad (word_bad),
        .wr_word  (wr_word_next),
        .wr_be    (wr_be_next)
    );

    always_comb begin
        unique case (kind_e)
            ACC_WORD:                       ld_next = word_bad ? '0 : rd_word;
            ACC_SBYTE, ACC_UBYTE, ACC_RSVD: ld_next = byte_value;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_value <= '0;
            wr_word  <= '0;
            wr_be    <= '0;
            misalign <= 1'b0;
        end else begin
            ld_value <= ld_next;
            wr_word  <= wr_word_next;
            wr_be    <= wr_be_next;
            misalign <= word_bad;
        end
    end

    // ---------------- assertions ----------------
    a_r3_word_load_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 2'b00 && addr_lo == '0) |=> (ld_value == $past(rd_word)));

    a_r6_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 2'b01) |=> (ld_value[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){ld_value[BYTE_W-1]}}));

    a_r7_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (kind[1] == 1'b1) |=> (ld_value[DATA_W-1:BYTE_W] == '0));

    a_r8_word_store: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en && kind == 2'b00 && addr_lo == '0) |=> (wr_be == {NB{1'b1}} && wr_word == $past(st_data)));

    a_r9_byte_store_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en && kind != 2'b00) |=> ($countones(wr_be) == 1 && wr_word == {NB{$past(st_data[BYTE_W-1:0])}}));

    a_r10_misalign: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 2'b00 && addr_lo != '0) |=> (misalign && wr_be == '0 && ld_value == '0));

    a_r10_byte_never_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != 2'b00) |=> !misalign);

    a_r11_no_store_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !st_en |=> (wr_be == '0));

endmodule

// File: tb/lsu_lane_unit_test.sv
module lsu_lane_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_endian = 1'b0;
    logic [1:0]  kind = 2'b00;
    logic [1:0]  addr_lo = 2'b00;
    logic        st_en = 1'b0;
    logic [31:0] rd_word = '0;
    logic [31:0] st_data = '0;
    logic [31:0] ld_value;
    logic [31:0] wr_word;
    logic [3:0]  wr_be;
    logic        misalign;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lsu_lane_unit uut (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .kind(kind),
        .addr_lo(addr_lo), .st_en(st_en), .rd_word(rd_word), .st_data(st_data),
        .ld_value(ld_value), .wr_word(wr_word), .wr_be(wr_be), .misalign(misalign)
    );

    typedef struct packed {
        logic        be;
        logic [1:0]  kd;
        logic [1:0]  ad;
        logic        st;
        logic [31:0] rd;
        logic [31:0] sd;
        logic [31:0] e_ld;
        logic [31:0] e_ww;
        logic [3:0]  e_be;
        logic        e_mis;
    } vec_t;

    localparam logic [31:0] RW = 32'h119233F4; // lane3=11 lane2=92 lane1=33 lane0=F4
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'b00, 2'd0, 1'b0, RW, 32'h0,        RW,           32'h0,        4'b0000, 1'b0}, // R3 LE
        '{1'b1, 2'b00, 2'd0, 1'b0, RW, 32'h0,        RW,           32'h0,        4'b0000, 1'b0}, // R3 BE
        '{1'b0, 2'b01, 2'd0, 1'b0, RW, 32'h0,        32'hFFFFFFF4, 32'h0,        4'b0000, 1'b0}, // R4 R6
        '{1'b1, 2'b01, 2'd0, 1'b0, RW, 32'h0,        32'h00000011, 32'h0,        4'b0000, 1'b0}, // R5 R6
        '{1'b0, 2'b10, 2'd2, 1'b0, RW, 32'h0,        32'h00000092, 32'h0,        4'b0000, 1'b0}, // R4 R7
        '{1'b1, 2'b10, 2'd1, 1'b0, RW, 32'h0,        32'h00000092, 32'h0,        4'b0000, 1'b0}, // R5 R7
        '{1'b1, 2'b01, 2'd1, 1'b0, RW, 32'h0,        32'hFFFFFF92, 32'h0,        4'b0000, 1'b0}, // R5 R6
        '{1'b0, 2'b01, 2'd3, 1'b0, RW, 32'h0,        32'h00000011, 32'h0,        4'b0000, 1'b0}, // R4 R6
        '{1'b0, 2'b00, 2'd0, 1'b1, RW, 32'hDEADBEEF, RW,           32'hDEADBEEF, 4'b1111, 1'b0}, // R8 LE
        '{1'b1, 2'b00, 2'd0, 1'b1, RW, 32'hDEADBEEF, RW,           32'hDEADBEEF, 4'b1111, 1'b0}, // R8 BE
        '{1'b0, 2'b01, 2'd1, 1'b1, RW, 32'h000000A5, 32'h00000033, 32'hA5A5A5A5, 4'b0010, 1'b0}, // R9 LE
        '{1'b1, 2'b10, 2'd1, 1'b1, RW, 32'h123456C7, 32'h00000092, 32'hC7C7C7C7, 4'b0100, 1'b0}, // R9 BE
        '{1'b1, 2'b10, 2'd3, 1'b1, RW, 32'h123456C7, 32'h000000F4, 32'hC7C7C7C7, 4'b0001, 1'b0}, // R9 BE
        '{1'b0, 2'b00, 2'd2, 1'b1, RW, 32'hDEADBEEF, 32'h0,        32'hDEADBEEF, 4'b0000, 1'b1}, // R10
        '{1'b1, 2'b11, 2'd0, 1'b0, RW, 32'h0,        32'h00000011, 32'h0,        4'b0000, 1'b0}  // R7 reserved
    };

    task automatic check32(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic b, input logic [1:0] k, input logic [1:0] a,
                         input logic s, input logic [31:0] r, input logic [31:0] d);
        big_endian = b; kind = k; addr_lo = a; st_en = s; rd_word = r; st_data = d;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset holds outputs at zero even with active inputs
        apply(1'b1, 2'b00, 2'd0, 1'b1, 32'hCAFEF00D, 32'h89ABCDEF);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check32("R1", "ld_value", ld_value, 32'h0);
        check32("R1", "wr_word",  wr_word,  32'h0);
        check32("R1", "wr_be",    {28'h0, wr_be}, 32'h0);
        check32("R1", "misalign", {31'h0, misalign}, 32'h0);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VECS[i].be, VECS[i].kd, VECS[i].ad, VECS[i].st, VECS[i].rd, VECS[i].sd);
            @(posedge clk);
            #1;
            check32("R3-R10 vec", "ld_value", ld_value, VECS[i].e_ld);
            check32("R3-R10 vec", "wr_word",  wr_word,  VECS[i].e_ww);
            check32("R9 R10 R11 vec", "wr_be", {28'h0, wr_be}, {28'h0, VECS[i].e_be});
            check32("R10 vec", "misalign", {31'h0, misalign}, {31'h0, VECS[i].e_mis});
        end

        // R2: new inputs between edges do not reach the outputs until the edge
        @(negedge clk);
        apply(1'b0, 2'b00, 2'd0, 1'b1, 32'h01020304, 32'h55667788);
        @(posedge clk);
        #1;
        @(negedge clk);
        apply(1'b0, 2'b10, 2'd1, 1'b0, 32'h01020304, 32'h0);
        #1;
        check32("R2", "ld_value hold", ld_value, 32'h01020304);
        check32("R2", "wr_be hold", {28'h0, wr_be}, 32'hF);
        @(posedge clk);
        #1;
        check32("R2", "ld_value update", ld_value, 32'h00000003);

        // R11: byte kind with st_en low writes nothing
        @(negedge clk);
        apply(1'b1, 2'b01, 2'd2, 1'b0, 32'h01020304, 32'h000000FF);
        @(posedge clk);
        #1;
        check32("R11", "wr_be", {28'h0, wr_be}, 32'h0);
        check32("R5", "ld_value", ld_value, 32'h00000003);

        // R6 boundary: 0x7F stays positive, 0x80 goes negative (LE offset 0)
        @(negedge clk);
        apply(1'b0, 2'b01, 2'd0, 1'b0, 32'h0000007F, 32'h0);
        @(posedge clk);
        #1;
        check32("R6", "ld 7F", ld_value, 32'h0000007F);
        @(negedge clk);
        apply(1'b0, 2'b01, 2'd0, 1'b0, 32'h00000080, 32'h0);
        @(posedge clk);
        #1;
        check32("R6", "ld 80", ld_value, 32'hFFFFFF80);

        // R10: misaligned word store, big-endian, offset 3
        @(negedge clk);
        apply(1'b1, 2'b00, 2'd3, 1'b1, 32'hFFFFFFFF, 32'h12345678);
        @(posedge clk);
        #1;
        check32("R10", "misalign", {31'h0, misalign}, 32'h1);
        check32("R10", "wr_be", {28'h0, wr_be}, 32'h0);
        check32("R10", "ld_value", ld_value, 32'h0);

        // R4: little-endian byte store at offset 3 enables lane 3
        @(negedge clk);
        apply(1'b0, 2'b01, 2'd3, 1'b1, 32'h0, 32'h0000003C);
        @(posedge clk);
        #1;
        check32("R4 R9", "wr_be", {28'h0, wr_be}, 32'h8);
        check32("R9", "wr_word", wr_word, 32'h3C3C3C3C);

        // R1: reset again clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check32("R1", "wr_be after reset", {28'h0, wr_be}, 32'h0);
        check32("R1", "wr_word after reset", wr_word, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule